// File: doc/BRIEF.md
# Color Grading Table Access Port

The block stores six color-grading lookup tables of 64 entries each. A host reaches them through two registers on a small synchronous read/write bus. The control register names a table, holds an entry index and picks the access mode. The data register reads or writes the entry that the control register points at. In step mode every access to the data register moves the index one entry forward, so a host can fill or dump a whole table with back-to-back data accesses.

A second read port serves the pixel pipeline. It takes a table code and an index, and returns the extended entry one cycle later. The hue-to-hue table holds 14-bit signed entries. The other five tables hold 12-bit unsigned entries. Both kinds are widened to 16 bits on every read.

Top module: `cgrade_tbl_port`

## Requirements
- R1: The control register (bus_addr = 0) holds the table code in bits 9:7, the entry index in bits 6:1 and the mode in bit 0 (0 = fixed, 1 = step). A read returns these fields with bits 15:10 always zero. Reset clears all fields to zero.
- R2: Table codes 0 to 5 select six independent 64-entry tables: 0 hue-vs-hue, 1 hue-vs-saturation, 2 lightness-vs-saturation, 3 saturation-vs-saturation, 4 lightness-vs-lightness, 5 hue-vs-lightness.
- R3: In fixed mode a read or write of the data register (bus_addr = 1) uses the index held in the control register, and that index does not change.
- R4: In step mode each read or write of the data register uses the current index and then increments it by one. The new index can be read back through the control register.
- R5: In step mode the index wraps from 63 to 0.
- R6: Table 0 stores bus_wdata[13:0]. A read returns that value sign-extended from bit 13 to 16 bits.
- R7: Tables 1 to 5 store bus_wdata[11:0]. A read returns that value zero-extended to 16 bits.
- R8: With table code 6 or 7, data writes change no table and data reads return zero, although step mode still advances the index. The pixel port returns zero for codes 6 and 7.
- R9: bus_rdata carries the result one cycle after a cycle with bus_rd high, and is zero after any other cycle. When bus_wr and bus_rd are both high, only the write is performed, and the index steps once at most.
- R10: px_data returns the extended entry addressed by px_table and px_index one cycle later. If the host writes the same entry in that cycle, px_data shows the entry's old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | 0 = control register, 1 = data register |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, one cycle after bus_rd |
| px_table | input | 3 | Pixel-side table code |
| px_index | input | 6 | Pixel-side entry index |
| px_data | output | 16 | Pixel-side entry, one cycle after the request |

## Verification
Each host read and each pixel lookup is due exactly one clock edge after the cycle that requests it. A data-register access also changes the index at that same edge. Inputs are applied just after a rising edge. A reference model evaluates them at the following falling edge, so it sees the index as it was before the edge that acts on them. The model works out what both outputs must show after the next rising edge and compares them at the falling edge after that. Directed control-register reads after fixed-mode, step-mode, wrap and reserved-code sequences check the index at the ports.

// File: rtl/cgrade_pkg.sv
package cgrade_pkg;
  localparam int NUM_TBL  = 6;
  localparam int TBL_BITS = 3;
  localparam int IDX_BITS = 6;
  localparam int DATA_W   = 16;
  localparam int HUE_W    = 14;
  localparam int STD_W    = 12;

  // entry width of each table: table 0 carries signed hue offsets
  function automatic int tbl_width(int t);
    return (t == 0) ? HUE_W : STD_W;
  endfunction

  typedef enum logic [1:0] {RK_NONE, RK_CTRL, RK_DATA} rd_kind_e;
endpackage

// File: rtl/cgrade_switch_reg.sv
module cgrade_switch_reg #(
  parameter int TBL_BITS = cgrade_pkg::TBL_BITS,
  parameter int IDX_BITS = cgrade_pkg::IDX_BITS,
  parameter int DATA_W   = cgrade_pkg::DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_wr,
  input  logic [DATA_W-1:0]   ctrl_wdata,
  input  logic                data_acc,
  output logic [TBL_BITS-1:0] tbl_o,
  output logic [IDX_BITS-1:0] idx_o,
  output logic                step_o,
  output logic [DATA_W-1:0]   ctrl_word_o
);
  localparam int IDX_LSB = 1;
  localparam int TBL_LSB = IDX_LSB + IDX_BITS;
  localparam int USED    = TBL_LSB + TBL_BITS;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_o  <= '0;
      idx_o  <= '0;
      step_o <= 1'b0;
    end else if (ctrl_wr) begin
      tbl_o  <= ctrl_wdata[TBL_LSB +: TBL_BITS];
      idx_o  <= ctrl_wdata[IDX_LSB +: IDX_BITS];
      step_o <= ctrl_wdata[0];
    end else if (data_acc && step_o) begin
      idx_o <= idx_o + 1'b1;
    end
  end

  assign ctrl_word_o = {{(DATA_W-USED){1'b0}}, tbl_o, idx_o, step_o};
endmodule

// File: rtl/cgrade_table_bank.sv
module cgrade_table_bank #(
  parameter int NUM_TBL  = cgrade_pkg::NUM_TBL,
  parameter int TBL_BITS = cgrade_pkg::TBL_BITS,
  parameter int IDX_BITS = cgrade_pkg::IDX_BITS,
  parameter int DATA_W   = cgrade_pkg::DATA_W
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [TBL_BITS-1:0] wr_tbl,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [TBL_BITS-1:0] h_tbl,
  input  logic [IDX_BITS-1:0] h_idx,
  output logic [DATA_W-1:0]   h_data,
  input  logic [TBL_BITS-1:0] p_tbl,
  input  logic [IDX_BITS-1:0] p_idx,
  output logic [DATA_W-1:0]   p_data
);
  localparam int DEPTH = 1 << IDX_BITS;

  logic [DATA_W-1:0]   h_ext [NUM_TBL];
  logic [DATA_W-1:0]   p_ext [NUM_TBL];
  logic [TBL_BITS-1:0] h_sel_q, p_sel_q;

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    localparam int W = cgrade_pkg::tbl_width(t);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] hq, pq;

    // one write port, two registered read ports (read-before-write)
    always_ff @(posedge clk) begin
      if (wr_en && (wr_tbl == TBL_BITS'(t))) mem[wr_idx] <= wr_data[W-1:0];
      hq <= mem[h_idx];
      pq <= mem[p_idx];
    end

    if (t == 0) begin : g_signed
      assign h_ext[t] = {{(DATA_W-W){hq[W-1]}}, hq};
      assign p_ext[t] = {{(DATA_W-W){pq[W-1]}}, pq};
    end else begin : g_unsigned
      assign h_ext[t] = {{(DATA_W-W){1'b0}}, hq};
      assign p_ext[t] = {{(DATA_W-W){1'b0}}, pq};
    end
  end

  always_ff @(posedge clk) begin
    h_sel_q <= h_tbl;
    p_sel_q <= p_tbl;
  end

  always_comb begin
    h_data = '0;
    p_data = '0;
    for (int t = 0; t < NUM_TBL; t++) begin
      if (h_sel_q == TBL_BITS'(t)) h_data = h_ext[t];
      if (p_sel_q == TBL_BITS'(t)) p_data = p_ext[t];
    end
  end
endmodule

// File: rtl/cgrade_tbl_port.sv
module cgrade_tbl_port #(
  parameter int NUM_TBL  = cgrade_pkg::NUM_TBL,
  parameter int TBL_BITS = cgrade_pkg::TBL_BITS,
  parameter int IDX_BITS = cgrade_pkg::IDX_BITS,
  parameter int DATA_W   = cgrade_pkg::DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [TBL_BITS-1:0] px_table,
  input  logic [IDX_BITS-1:0] px_index,
  output logic [DATA_W-1:0]   px_data
);
  import cgrade_pkg::*;

  logic                ctrl_wr, data_wr, rd_eff, data_acc;
  logic [TBL_BITS-1:0] cur_tbl;
  logic [IDX_BITS-1:0] cur_idx;
  logic                cur_step;
  logic [DATA_W-1:0]   ctrl_word, ctrl_snap_q, host_entry;
  rd_kind_e            kind_q;

  assign ctrl_wr  = bus_wr && !bus_addr;
  assign data_wr  = bus_wr && bus_addr;
  assign rd_eff   = bus_rd && !bus_wr;
  assign data_acc = bus_addr && (bus_wr || bus_rd);

  cgrade_switch_reg #(
    .TBL_BITS(TBL_BITS), .IDX_BITS(IDX_BITS), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(bus_wdata),
    .data_acc(data_acc), .tbl_o(cur_tbl), .idx_o(cur_idx),
    .step_o(cur_step), .ctrl_word_o(ctrl_word)
  );

  cgrade_table_bank #(
    .NUM_TBL(NUM_TBL), .TBL_BITS(TBL_BITS), .IDX_BITS(IDX_BITS), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .wr_en(data_wr), .wr_tbl(cur_tbl), .wr_idx(cur_idx),
    .wr_data(bus_wdata), .h_tbl(cur_tbl), .h_idx(cur_idx), .h_data(host_entry),
    .p_tbl(px_table), .p_idx(px_index), .p_data(px_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q      <= RK_NONE;
      ctrl_snap_q <= '0;
    end else begin
      kind_q      <= !rd_eff ? RK_NONE : (bus_addr ? RK_DATA : RK_CTRL);
      ctrl_snap_q <= ctrl_word;
    end
  end

  always_comb begin
    case (kind_q)
      RK_CTRL: bus_rdata = ctrl_snap_q;
      RK_DATA: bus_rdata = host_entry;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cgrade_chk.sv
module cgrade_chk #(
  parameter int NUM_TBL  = cgrade_pkg::NUM_TBL,
  parameter int TBL_BITS = cgrade_pkg::TBL_BITS,
  parameter int IDX_BITS = cgrade_pkg::IDX_BITS,
  parameter int DATA_W   = cgrade_pkg::DATA_W
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic                bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [TBL_BITS-1:0] px_table,
  input logic [DATA_W-1:0]   px_data,
  input logic [TBL_BITS-1:0] cur_tbl,
  input logic [IDX_BITS-1:0] cur_idx,
  input logic                cur_step
);
  localparam int USED = TBL_BITS + IDX_BITS + 1;

  AST_CTRL_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && !bus_addr) |=> (bus_rdata[DATA_W-1:USED] == '0)); // R1
  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cur_step && bus_addr && (bus_wr || bus_rd)) |=> $stable(cur_idx)); // R3
  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (cur_step && bus_addr && (bus_wr || bus_rd)) |=> (cur_idx == IDX_BITS'($past(cur_idx) + 1))); // R4
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cur_step && bus_addr && (bus_wr || bus_rd) && (&cur_idx)) |=> (cur_idx == '0)); // R5
  AST_HUE_SEXT: assert property (@(posedge clk) disable iff (rst)
    (px_table == '0) |=> ((px_data[DATA_W-1:13] == '0) || (&px_data[DATA_W-1:13]))); // R6
  AST_STD_ZEXT: assert property (@(posedge clk) disable iff (rst)
    ((px_table != '0) && (px_table < TBL_BITS'(NUM_TBL))) |=> (px_data[DATA_W-1:12] == '0)); // R7
  AST_RSVD_PX_ZERO: assert property (@(posedge clk) disable iff (rst)
    (px_table >= TBL_BITS'(NUM_TBL)) |=> (px_data == '0)); // R8
  AST_RSVD_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr && (cur_tbl >= TBL_BITS'(NUM_TBL))) |=> (bus_rdata == '0)); // R8
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_wr) |=> (bus_rdata == '0)); // R9
endmodule

bind cgrade_tbl_port cgrade_chk #(
  .NUM_TBL(NUM_TBL), .TBL_BITS(TBL_BITS), .IDX_BITS(IDX_BITS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .px_table(px_table), .px_data(px_data),
  .cur_tbl(cur_tbl), .cur_idx(cur_idx), .cur_step(cur_step)
);

// File: tb/test_cgrade_tbl_port.sv
`timescale 1ns/1ps
module test_cgrade_tbl_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [2:0]  px_table = '0;
  logic [5:0]  px_index = '0;
  wire  [15:0] bus_rdata, px_data;

  cgrade_tbl_port i_cgrade_tbl_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .px_table(px_table), .px_index(px_index), .px_data(px_data)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, pcnt = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
    end
  endtask

  // reference model state
  int    m_tbl = 0, m_idx = 0, m_step = 0;
  int    ref_mem [8][64];
  bit    ref_ok  [8][64];
  bit    have_rd = 1'b0, have_px = 1'b0;
  int    exp_rd = 0, exp_px = 0;
  string tag_rd = "", tag_px = "";

  function automatic int extv(int t, int v);
    if (t == 0) return ((v & 32'h2000) != 0) ? ((v & 32'h3fff) | 32'hc000) : (v & 32'h3fff);
    return v & 32'h0fff;
  endfunction

  always @(negedge clk) begin
    if (have_rd) chk(tag_rd, int'(bus_rdata), exp_rd);
    if (have_px) chk(tag_px, int'(px_data), exp_px);
    if (rst) begin
      m_tbl = 0; m_idx = 0; m_step = 0;
      exp_rd = 0; tag_rd = "R1 R9 reset rdata"; have_rd = 1'b1; have_px = 1'b0;
    end else begin
      exp_rd = 0; tag_rd = "R9 idle rdata";
      if (bus_wr) tag_rd = "R9 write wins";
      else if (bus_rd && !bus_addr) begin
        exp_rd = (m_tbl << 7) | (m_idx << 1) | m_step; tag_rd = "R1 control read";
      end else if (bus_rd) begin
        if (m_tbl < 6) begin
          exp_rd = extv(m_tbl, ref_mem[m_tbl][m_idx]);
          tag_rd = (m_tbl == 0) ? "R2 R6 hue read" : "R2 R7 std read";
        end else tag_rd = "R8 reserved read";
      end
      have_rd = 1'b1;
      if (px_table >= 3'd6) begin
        have_px = 1'b1; exp_px = 0; tag_px = "R8 px reserved";
      end else if (ref_ok[px_table][px_index]) begin
        have_px = 1'b1; exp_px = extv(int'(px_table), ref_mem[px_table][px_index]);
        tag_px = "R10 px read";
      end else have_px = 1'b0;
      if (bus_wr && !bus_addr) begin
        m_tbl = int'(bus_wdata[9:7]); m_idx = int'(bus_wdata[6:1]); m_step = int'(bus_wdata[0]);
      end else if (bus_wr && bus_addr && m_tbl < 6) begin
        ref_mem[m_tbl][m_idx] = int'(bus_wdata); ref_ok[m_tbl][m_idx] = 1'b1;
      end
      if (bus_addr && (bus_wr || bus_rd) && m_step != 0) m_idx = (m_idx + 1) % 64;
    end
  end

  task automatic step();
    @(posedge clk); #1;
    px_table = 3'(pcnt % 8);
    px_index = 6'((pcnt * 7) % 64);
    pcnt++;
  endtask

  task automatic op(bit wr, bit rd, bit addr, logic [15:0] d);
    step();
    bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = d;
  endtask

  function automatic logic [15:0] cw(int t, int i, int s);
    return 16'((t << 7) | (i << 1) | s);
  endfunction

  task automatic ctrl_expect(string tag, logic [15:0] e);
    op(0, 1, 0, '0);
    op(0, 0, 0, '0);
    chk(tag, int'(bus_rdata), int'(e));
  endtask

  initial begin
    repeat (4) step();
    rst = 1'b0;
    step();
    ctrl_expect("R1 reset control zero", 16'h0000);
    for (int t = 0; t < 6; t++) begin
      op(1, 0, 0, cw(t, 0, 1));
      for (int i = 0; i < 64; i++) op(1, 0, 1, 16'((i * 613 + t * 4099) ^ 16'h5a3c));
    end
    for (int t = 0; t < 6; t++) begin
      op(1, 0, 0, cw(t, 0, 1));
      for (int i = 0; i < 64; i++) op(0, 1, 1, '0);
    end
    ctrl_expect("R5 wrap after 64 steps", cw(5, 0, 1));
    op(1, 0, 0, cw(0, 5, 0));
    repeat (3) op(0, 1, 1, '0);
    op(1, 0, 1, 16'h2001);
    op(0, 1, 1, '0);
    ctrl_expect("R3 fixed index held", cw(0, 5, 0));
    op(1, 0, 0, cw(2, 60, 1));
    repeat (6) op(0, 1, 1, '0);
    ctrl_expect("R4 R5 step from 60 by 6", cw(2, 2, 1));
    op(1, 0, 0, cw(6, 10, 1));
    repeat (3) op(1, 0, 1, 16'hffff);
    repeat (2) op(0, 1, 1, '0);
    ctrl_expect("R8 reserved code still steps", cw(6, 15, 1));
    op(1, 0, 0, cw(7, 0, 0));
    op(1, 0, 1, 16'h1234);
    op(0, 1, 1, '0);
    op(1, 0, 0, cw(3, 0, 1));
    op(1, 1, 1, 16'h0abc);
    op(0, 1, 1, '0);
    ctrl_expect("R9 read+write steps once", cw(3, 2, 1));
    op(1, 0, 0, 16'hfc00 | cw(1, 33, 0));
    ctrl_expect("R1 reserved bits read zero", cw(1, 33, 0));
    op(1, 0, 0, cw(4, 0, 1));
    for (int k = 0; k < 200; k++) op(1, 0, 1, 16'(k * 29 + 7));
    op(0, 0, 0, '0);
    repeat (600) step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule